// File: doc/BRIEF.md
# Bus-Master FIFO Channel with Byte-Order Translation

This block carries 32-bit words in one direction between a host bus and a local add-on bus. The words pass through an eight-entry FIFO. The channel acts as a simple bus master on the host side. It holds an address pointer that it puts out with every request, and a 26-bit byte count of the work left. Each accepted host beat moves one word, adds four to the pointer and takes four bytes off the count. When the count reaches zero the channel stops requesting and raises a sticky terminal-count flag toward each side.

The parameter `TO_LOCAL` sets the direction. With `TO_LOCAL=1`, host beats fill the FIFO and the local side drains it with a read strobe. With `TO_LOCAL=0`, the local side fills it with a write strobe and host beats drain it. Byte-order translation is applied to host-side data only, so words on the local side keep the same layout in every mode.

Top module: `bm_fifo_chan`

## Requirements
- R1: After reset, fifo_empty=1, fifo_full=0, host_req=0, host_addr=0, xfer_left=0, host_irq=0 and loc_irq=0.
- R2: The FIFO holds up to 8 words and returns them in arrival order. fifo_empty is 1 when it holds none and fifo_full is 1 when it holds 8. loc_rdata (TO_LOCAL=1) or the source word of host_rdata (TO_LOCAL=0) is the oldest word.
- R3: A push when the FIFO is full and a pop when it is empty are dropped. The contents and the fill level do not change.
- R4: addr_ld loads host_addr with addr_ld_val and forces bits 1:0 to zero. Each host beat (host_req and host_ack both 1) adds 4 to host_addr. A load in the same cycle as a beat wins.
- R5: Each host beat lowers xfer_left by 4. A value of 4 or less goes to 0. cnt_ld loads cnt_ld_val and wins over a beat in the same cycle.
- R6: host_req is 1 only when run_en=1, xfer_left is nonzero, and the FIFO has room (TO_LOCAL=1) or has data (TO_LOCAL=0).
- R7: endian_sel sets the host-side translation. 00 passes the word through. 01 reverses all four bytes. 10 swaps the two bytes in each 16-bit half. 11 swaps the two 16-bit halves. The translation is applied when a host word is pushed (TO_LOCAL=1) and when the host reads the head word (TO_LOCAL=0).
- R8: A beat that takes xfer_left from nonzero to zero, with no count load in that cycle, sets the host flag and the local flag in the next cycle. Each flag stays set until its clear strobe (host_irq_clr, loc_irq_clr), and a set in the same cycle wins over a clear. host_irq = host flag AND host_irq_en. loc_irq = local flag AND loc_irq_en.
- R9: Loading the count, to zero or to any other value, never sets the terminal flags.
- R10: With TO_LOCAL=0, loc_wr pushes loc_wdata and each host beat pops the head word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Allows master requests |
| endian_sel | input | 2 | Byte-order translation mode |
| addr_ld | input | 1 | Load strobe for the address pointer |
| addr_ld_val | input | 32 | Address value to load |
| cnt_ld | input | 1 | Load strobe for the byte count |
| cnt_ld_val | input | 26 | Byte count value to load |
| host_req | output | 1 | Master request for one word beat |
| host_ack | input | 1 | Host accepts the beat this cycle |
| host_addr | output | 32 | Current master address |
| host_wdata | input | 32 | Host word into the FIFO (TO_LOCAL=1) |
| host_rdata | output | 32 | Translated head word toward the host (TO_LOCAL=0) |
| loc_rd | input | 1 | Local pop strobe (TO_LOCAL=1) |
| loc_wr | input | 1 | Local push strobe (TO_LOCAL=0) |
| loc_wdata | input | 32 | Local word into the FIFO |
| loc_rdata | output | 32 | Head word toward the local side |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_full | output | 1 | FIFO holds eight words |
| xfer_left | output | 26 | Remaining byte count |
| host_irq_en | input | 1 | Host interrupt enable |
| loc_irq_en | input | 1 | Local interrupt enable |
| host_irq_clr | input | 1 | Clears the host terminal flag |
| loc_irq_clr | input | 1 | Clears the local terminal flag |
| host_irq | output | 1 | Host terminal-count interrupt |
| loc_irq | output | 1 | Local terminal-count interrupt |

## Verification
The host-to-local channel runs under random acks, local pops, run_en gating, endian modes, address loads and small count loads. This drives the count into zero often, so the bench sees both terminal detection and count loads that must not raise the flags. Local reads on an empty FIFO and a FIFO held full by a slow reader show apart the empty and full gating of requests. The local-to-host channel is then driven in a directed way. A ninth push into a full FIFO must be dropped. A fixed word is read in all four endian modes, to tell the byte-reversal patterns apart. A count that runs out while data is still queued shows apart the count stop and the empty stop.

// File: rtl/bm_fifo_chan.sv
module bm_fifo_chan #(
  parameter int DEPTH = 8,
  parameter int CW = 26,
  parameter int AW = 32,
  parameter bit TO_LOCAL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [1:0]    endian_sel,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_ld_val,
  input  logic          cnt_ld,
  input  logic [CW-1:0] cnt_ld_val,
  output logic          host_req,
  input  logic          host_ack,
  output logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          loc_rd,
  input  logic          loc_wr,
  input  logic [31:0]   loc_wdata,
  output logic [31:0]   loc_rdata,
  output logic          fifo_empty,
  output logic          fifo_full,
  output logic [CW-1:0] xfer_left,
  input  logic          host_irq_en,
  input  logic          loc_irq_en,
  input  logic          host_irq_clr,
  input  logic          loc_irq_clr,
  output logic          host_irq,
  output logic          loc_irq
);
  localparam int PW = $clog2(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   fill;
  logic [AW-1:0] addr;
  logic [CW-1:0] cnt;
  logic          hflag, lflag;
  logic          push, pop, beat, tc;
  logic [31:0]   push_data;
  logic          unused_in;

  function automatic logic [31:0] xlate(input logic [31:0] d, input logic [1:0] m);
    case (m)
      2'b01:   xlate = {d[7:0], d[15:8], d[23:16], d[31:24]};
      2'b10:   xlate = {d[23:16], d[31:24], d[7:0], d[15:8]};
      2'b11:   xlate = {d[15:0], d[31:16]};
      default: xlate = d;
    endcase
  endfunction

  assign fifo_empty = (fill == '0);
  assign fifo_full  = (fill == (PW+1)'(DEPTH));
  assign host_req   = run_en && (cnt != '0) && (TO_LOCAL ? !fifo_full : !fifo_empty);
  assign beat       = host_req && host_ack;
  assign tc         = beat && !cnt_ld && (cnt <= CW'(4));

  generate
    if (TO_LOCAL) begin : g_h2l
      assign push      = beat;
      assign push_data = xlate(host_wdata, endian_sel);
      assign pop       = loc_rd && !fifo_empty;
      assign unused_in = ^{loc_wr, loc_wdata};
    end else begin : g_l2h
      assign push      = loc_wr && !fifo_full;
      assign push_data = loc_wdata;
      assign pop       = beat;
      assign unused_in = ^{loc_rd, host_wdata};
    end
  endgenerate

  assign loc_rdata  = mem[rp];
  assign host_rdata = xlate(mem[rp], endian_sel);
  assign host_addr  = addr;
  assign xfer_left  = cnt;
  assign host_irq   = hflag && host_irq_en;
  assign loc_irq    = lflag && loc_irq_en;

  always_ff @(posedge clk)
    if (push) mem[wp] <= push_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      fill <= fill + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      cnt <= '0;
      hflag <= 1'b0;
      lflag <= 1'b0;
    end else begin
      if (addr_ld)   addr <= {addr_ld_val[AW-1:2], 2'b00};
      else if (beat) addr <= addr + AW'(4);
      if (cnt_ld)    cnt <= cnt_ld_val;
      else if (beat) cnt <= (cnt <= CW'(4)) ? '0 : cnt - CW'(4);
      hflag <= tc || (hflag && !host_irq_clr);
      lflag <= tc || (lflag && !loc_irq_clr);
    end
  end

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (PW+1)'(DEPTH));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !pop) |=> fifo_full && $stable(wp));
  assert_addr_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr[1:0] == 2'b00);
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !addr_ld) |=> host_addr == $past(host_addr) + AW'(4));
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !cnt_ld) |=> xfer_left < $past(xfer_left));
  assert_req_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_left == '0) |-> !host_req);
  assert_tc_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hflag) || $rose(lflag)) |-> (xfer_left == '0));
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> (xfer_left == $past(cnt_ld_val)) && !$rose(hflag));
endmodule

// File: tb/bm_fifo_chan_bench.sv
module bm_fifo_chan_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run_en = 0, addr_ld = 0, cnt_ld = 0, host_ack = 0, loc_rd = 0, loc_wr = 0;
  logic host_irq_en = 0, loc_irq_en = 0, host_irq_clr = 0, loc_irq_clr = 0;
  logic [1:0] endian_sel = 0;
  logic [31:0] addr_ld_val = 0, host_wdata = 0, loc_wdata = 0;
  logic [25:0] cnt_ld_val = 0;
  logic a_req, a_empty, a_full, a_hirq, a_lirq;
  logic [31:0] a_addr, a_hrd, a_lrd;
  logic [25:0] a_left;
  logic b_req, b_empty, b_full, b_hirq, b_lirq;
  logic [31:0] b_addr, b_hrd, b_lrd;
  logic [25:0] b_left;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bm_fifo_chan u_bm_fifo_chan (.clk, .rst_n, .run_en, .endian_sel, .addr_ld, .addr_ld_val,
    .cnt_ld, .cnt_ld_val, .host_req(a_req), .host_ack, .host_addr(a_addr), .host_wdata,
    .host_rdata(a_hrd), .loc_rd, .loc_wr, .loc_wdata, .loc_rdata(a_lrd),
    .fifo_empty(a_empty), .fifo_full(a_full), .xfer_left(a_left), .host_irq_en,
    .loc_irq_en, .host_irq_clr, .loc_irq_clr, .host_irq(a_hirq), .loc_irq(a_lirq));

  bm_fifo_chan #(.TO_LOCAL(1'b0)) u_bm_fifo_chan_l2h (.clk, .rst_n, .run_en, .endian_sel,
    .addr_ld, .addr_ld_val, .cnt_ld, .cnt_ld_val, .host_req(b_req), .host_ack,
    .host_addr(b_addr), .host_wdata, .host_rdata(b_hrd), .loc_rd, .loc_wr, .loc_wdata,
    .loc_rdata(b_lrd), .fifo_empty(b_empty), .fifo_full(b_full), .xfer_left(b_left),
    .host_irq_en, .loc_irq_en, .host_irq_clr, .loc_irq_clr, .host_irq(b_hirq),
    .loc_irq(b_lirq));

  function automatic logic [31:0] ref_swap(input logic [31:0] d, input logic [1:0] m);
    logic [7:0] b0 = d[7:0], b1 = d[15:8], b2 = d[23:16], b3 = d[31:24];
    if (m == 2'd1) return {b0, b1, b2, b3};
    if (m == 2'd2) return {b2, b3, b0, b1};
    if (m == 2'd3) return {b1, b0, b3, b2};
    return d;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 0; run_en = 0; addr_ld = 0; cnt_ld = 0; host_ack = 0; loc_rd = 0; loc_wr = 0;
    host_irq_clr = 0; loc_irq_clr = 0;
    tick(); tick(); rst_n = 1;
  endtask

  logic [31:0] q[$];
  logic [31:0] m_addr;
  logic [25:0] m_cnt;
  logic m_hf, m_lf;

  initial begin
    logic m_req, m_beat, m_tc;
    void'($urandom(32'd20240607));
    do_reset();
    @(negedge clk);
    // R1 reset state on both directions
    check("R1 empty", {a_empty, b_empty}, 2'b11);
    check("R1 full", {a_full, b_full}, 2'b00);
    check("R1 req", {a_req, b_req}, 2'b00);
    check("R1 addr", a_addr, 0);
    check("R1 count", a_left, 0);
    check("R1 irq", {a_hirq, a_lirq, b_hirq, b_lirq}, 0);
    tick();
    m_addr = 0; m_cnt = 0; m_hf = 0; m_lf = 0;
    for (int c = 0; c < 4000; c++) begin
      run_en = ($urandom % 8) != 0;
      endian_sel = 2'($urandom);
      host_ack = ($urandom % 3) != 0;
      loc_rd = (c % 400 < 150) ? 1'b0 : (($urandom % 4) == 0);
      addr_ld = ($urandom % 40) == 0;
      addr_ld_val = $urandom;
      cnt_ld = ($urandom % 20) == 0;
      cnt_ld_val = 26'($urandom % 48);
      host_wdata = $urandom;
      host_irq_clr = ($urandom % 10) == 0;
      loc_irq_clr = ($urandom % 10) == 0;
      if ($urandom % 50 == 0) host_irq_en = ~host_irq_en;
      if ($urandom % 50 == 0) loc_irq_en = ~loc_irq_en;
      @(negedge clk);
      m_req = run_en && m_cnt != 0 && q.size() < 8;
      check("R6 host_req", a_req, m_req);
      check("R4 host_addr", a_addr, m_addr);
      check("R5 xfer_left", a_left, m_cnt);
      check("R2 empty/full", {a_empty, a_full}, {q.size() == 0, q.size() == 8});
      if (q.size() > 0) check("R7 R2 loc_rdata", a_lrd, q[0]);
      check("R8 irqs", {a_hirq, a_lirq}, {m_hf && host_irq_en, m_lf && loc_irq_en});
      m_beat = m_req && host_ack;
      if (loc_rd && q.size() > 0) void'(q.pop_front());
      if (m_beat) q.push_back(ref_swap(host_wdata, endian_sel));
      m_tc = m_beat && !cnt_ld && m_cnt <= 4;
      if (addr_ld) m_addr = {addr_ld_val[31:2], 2'b00};
      else if (m_beat) m_addr = m_addr + 4;
      if (cnt_ld) m_cnt = cnt_ld_val;
      else if (m_beat) m_cnt = (m_cnt <= 4) ? 26'd0 : m_cnt - 26'd4;
      m_hf = m_tc || (m_hf && !host_irq_clr);
      m_lf = m_tc || (m_lf && !loc_irq_clr);
      tick();
    end

    // Directed local-to-host channel: R10, R3, R7, R8, R9, R6
    do_reset();
    endian_sel = 0; host_irq_en = 1; loc_irq_en = 1;
    for (int i = 0; i < 9; i++) begin
      loc_wr = 1; loc_wdata = 32'h11223344 ^ i; tick();
    end
    loc_wr = 0;
    @(negedge clk);
    check("R2 l2h full", b_full, 1);
    cnt_ld = 1; cnt_ld_val = 16; addr_ld = 1; addr_ld_val = 32'h2003; tick();
    cnt_ld = 0; addr_ld = 0;
    @(negedge clk);
    check("R9 load no irq", {b_hirq, b_lirq}, 2'b00);
    check("R4 addr align", b_addr, 32'h2000);
    check("R6 disabled", b_req, 0);
    run_en = 1;
    for (int i = 0; i < 8; i++) begin
      if (i == 4) begin
        @(negedge clk);
        check("R5 count zero", b_left, 0);
        check("R6 count stop", b_req, 0);
        check("R4 addr after 4", b_addr, 32'h2010);
        check("R8 both irqs", {b_hirq, b_lirq}, 2'b11);
        host_irq_clr = 1; cnt_ld = 1; cnt_ld_val = 40; tick();
        host_irq_clr = 0; cnt_ld = 0;
        @(negedge clk);
        check("R8 clear host only", {b_hirq, b_lirq}, 2'b01);
      end
      endian_sel = 2'(i);
      #1;
      check("R6 l2h req", b_req, 1);
      check("R7 R10 host_rdata", b_hrd, ref_swap(32'h11223344 ^ i, 2'(i)));
      host_ack = 1; tick(); host_ack = 0;
    end
    @(negedge clk);
    check("R3 ninth dropped, empty", b_empty, 1);
    check("R6 empty stop", b_req, 0);
    check("R5 count left", b_left, 24);
    check("R7 mode 01 literal", ref_swap(32'h11223344, 2'd1), 32'h44332211);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule